// File: doc/BRIEF.md
# Write-Protect Disable Sequence Detector

This block sits beside a byte-wide nonvolatile memory with a 13-bit address and 8-bit data. It watches the write strobes on the memory bus. When it sees a fixed, ordered command of six address/data writes, it clears the software write-protection state. The write that completes the command starts a timed programming interval. During that interval the block reports busy and ignores every write. When the interval ends, the protection flag drops and the memory returns to normal operation.

The block also gives each incoming write a qualifier, `write_allowed`. This tells the memory array whether the write is an ordinary data write that may update storage. The qualifier is low while protection is on, while the block is busy, and for any write that the command detector takes as a command step. Protection is enabled by a separate one-cycle `protect_set` input. After reset, the flag takes a parameterised value, which models state held across power cycles.

Top module: `wpu_unlock_top`

## Requirements
- R1: When `rst_n` is low at a clock edge, the matcher goes back to the first step, `busy` goes low and `prot_en` takes the value of parameter `PROT_AT_RESET`. The default of that parameter is 1.
- R2: The unlock command is six writes in this order: 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555. Clock cycles with no write between the steps are allowed. `busy` rises in the cycle after the sixth write.
- R3: `busy` stays high for exactly `TWC_CYCLES` clock cycles and then falls.
- R4: `prot_en` keeps its value while `busy` is high. It falls at the same clock edge where `busy` falls.
- R5: A write that does not match the expected step aborts the command, and that write is not counted as progress. If the aborting write is 0xAA@0x1555, it is taken as a new first step. Otherwise the matcher returns to idle.
- R6: While `busy` is high, writes are ignored. They do not advance or reset the matcher, and `write_allowed` stays low.
- R7: While `prot_en` is high, `write_allowed` is low for every write.
- R8: A write that matches the expected step, or that is 0xAA@0x1555, is a command write. Its `write_allowed` is low even when protection is off.
- R9: `protect_set` high at a clock edge sets `prot_en` to 1. This takes priority over the clear at the end of the busy interval.
- R10: `write_allowed` is high, in the same cycle as `wr_pulse`, for any other write made while protection is off and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_pulse | input | 1 | One-cycle write strobe |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data |
| protect_set | input | 1 | Enables software write protection |
| prot_en | output | 1 | Software write protection is active |
| busy | output | 1 | Programming interval after the unlock command |
| write_allowed | output | 1 | Current write may update the array |

## Verification
The hardest case to reach from the ports is a command that restarts partway through. One example is a third write of 0xAA@0x1555 that fails step three but begins a new command, which must then complete in five more writes. Another is a `protect_set` that arrives in the very last busy cycle. Random stimulus alone rarely forms either case. So the bench drives them as directed sequences, then runs seeded random traffic that favours the next expected step and the restart pattern, so that full and broken commands both occur often. Each cycle is compared against a reference model in the bench.

// File: rtl/wpu_pkg.sv
// Package: shared widths and the unlock command table.
// Assumes a 13-bit address and 8-bit data bus, as the command values require.
package wpu_pkg;
    localparam int ADDR_W    = 13;
    localparam int DATA_W    = 8;
    localparam int NUM_STEPS = 6;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef logic [STEP_W-1:0] step_t;

    localparam logic [ADDR_W-1:0] ADDR_HI = 13'h1555;
    localparam logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA;

    // Address expected at command step idx.
    function automatic logic [ADDR_W-1:0] step_addr(input step_t idx);
        case (idx)
            3'd1, 3'd4: step_addr = ADDR_LO;
            default:    step_addr = ADDR_HI;
        endcase
    endfunction

    // Data expected at command step idx.
    function automatic logic [DATA_W-1:0] step_data(input step_t idx);
        case (idx)
            3'd0, 3'd3: step_data = 8'hAA;
            3'd1, 3'd4: step_data = 8'h55;
            3'd2:       step_data = 8'h80;
            default:    step_data = 8'h20;
        endcase
    endfunction
endpackage

// File: rtl/wpu_step_matcher.sv
// Module: tracks progress through the six-write unlock command.
// Assumes wr_pulse is at most one cycle per write; hold freezes the matcher.
module wpu_step_matcher
    import wpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold,
    output step_t             step_q,
    output logic              seq_done,
    output logic              cmd_write
);
    localparam step_t LAST = step_t'(NUM_STEPS - 1);

    logic hit_expected;
    logic hit_first;
    logic active_wr;

    // Classify the current write against the expected step and the opening step.
    always_comb begin
        active_wr    = wr_pulse && !hold;
        hit_expected = (wr_addr == step_addr(step_q)) && (wr_data == step_data(step_q));
        hit_first    = (wr_addr == step_addr('0)) && (wr_data == step_data('0));
        seq_done     = active_wr && hit_expected && (step_q == LAST);
        cmd_write    = active_wr && (hit_expected || hit_first);
    end

    // Advance on a match, restart or return to idle on a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (active_wr) begin
            if (hit_expected)
                step_q <= (step_q == LAST) ? '0 : step_q + step_t'(1);
            else
                step_q <= hit_first ? step_t'(1) : '0;
        end
    end
endmodule

// File: rtl/wpu_cycle_timer.sv
// Module: counts the programming interval that follows a completed command.
// Assumes start is never raised while the timer is running.
module wpu_cycle_timer #(
    parameter int TWC_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last_cycle
);
    localparam int CNT_W = $clog2(TWC_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(TWC_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Decode the busy window and its final cycle.
    always_comb begin
        busy       = (cnt_q != '0);
        last_cycle = (cnt_q == CNT_W'(1));
    end
endmodule

// File: rtl/wpu_prot_flag.sv
// Module: holds the software write-protection flag.
// Assumes clr is a single-cycle pulse at the end of the programming interval.
module wpu_prot_flag #(
    parameter bit PROT_AT_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic prot_q
);
    // Set wins over clear; reset loads the retained value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_q <= PROT_AT_RESET;
        else if (set)
            prot_q <= 1'b1;
        else if (clr)
            prot_q <= 1'b0;
    end
endmodule

// File: rtl/wpu_unlock_top.sv
// Module: write-protect disable detector top level.
// Connects the matcher, the interval timer and the protection flag, and qualifies writes.
// Assumes the write strobe, address and data are synchronous to clk.
module wpu_unlock_top
    import wpu_pkg::*;
#(
    parameter int TWC_CYCLES    = 16,
    parameter bit PROT_AT_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              protect_set,
    output logic              prot_en,
    output logic              busy,
    output logic              write_allowed
);
    step_t step_q;
    logic  seq_done;
    logic  cmd_write;
    logic  last_cycle;

    wpu_step_matcher u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pulse  (wr_pulse),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hold      (busy),
        .step_q    (step_q),
        .seq_done  (seq_done),
        .cmd_write (cmd_write)
    );

    wpu_cycle_timer #(.TWC_CYCLES(TWC_CYCLES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_done),
        .busy       (busy),
        .last_cycle (last_cycle)
    );

    wpu_prot_flag #(.PROT_AT_RESET(PROT_AT_RESET)) u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (protect_set),
        .clr    (last_cycle),
        .prot_q (prot_en)
    );

    // Pass only ordinary writes made while unprotected and idle.
    always_comb begin
        write_allowed = wr_pulse && !prot_en && !busy && !cmd_write;
    end
endmodule

// File: rtl/wpu_unlock_chk.sv
// Module: assertion checker for wpu_unlock_top, bound into every instance.
// Assumes it can see the matcher step through the bind connection.
module wpu_unlock_chk
    import wpu_pkg::*;
#(
    parameter int TWC_CYCLES    = 16,
    parameter bit PROT_AT_RESET = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_pulse,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              protect_set,
    input logic              prot_en,
    input logic              busy,
    input logic              write_allowed,
    input step_t             step_q
);
    int  run_len;
    logic exp_hit;
    logic first_hit;

    // Measure the length of each busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)  run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // Classify writes independently of the matcher.
    always_comb begin
        exp_hit   = (wr_addr == step_addr(step_q)) && (wr_data == step_data(step_q));
        first_hit = (wr_addr == ADDR_HI) && (wr_data == 8'hAA);
    end

    a_r2_busy_after_sixth: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !busy && step_q == step_t'(5) && wr_addr == ADDR_HI && wr_data == 8'h20)
        |=> (busy && step_q == '0));

    a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == TWC_CYCLES));

    a_r4_prot_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(protect_set)) |-> $stable(prot_en));

    a_r5_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !busy && !exp_hit && !first_hit) |=> (step_q == '0));

    a_r6_busy_holds_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step_q == $past(step_q)));

    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !write_allowed);

    a_r7_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        prot_en |-> !write_allowed);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        protect_set |=> prot_en);

    a_r2_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_q < step_t'(NUM_STEPS));
endmodule

bind wpu_unlock_top wpu_unlock_chk #(
    .TWC_CYCLES(TWC_CYCLES), .PROT_AT_RESET(PROT_AT_RESET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .protect_set(protect_set), .prot_en(prot_en),
    .busy(busy), .write_allowed(write_allowed), .step_q(step_q)
);

// File: tb/sim_wpu_unlock_top.sv
// Bench: directed corners plus seeded random traffic against a reference model.
module sim_wpu_unlock_top;
    localparam int TWC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_pulse = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        protect_set = 1'b0;
    logic        prot_en, busy, write_allowed;

    int checks = 0;
    int failures = 0;
    int m_step = 0;
    int m_cnt = 0;
    bit m_prot = 1'b1;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wpu_unlock_top #(.TWC_CYCLES(TWC), .PROT_AT_RESET(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
        .wr_data(wr_data), .protect_set(protect_set), .prot_en(prot_en),
        .busy(busy), .write_allowed(write_allowed)
    );

    function automatic logic [12:0] cmd_addr(int i);
        return (i == 1 || i == 4) ? 13'h0AAA : 13'h1555;
    endfunction

    function automatic logic [7:0] cmd_data(int i);
        case (i)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2:    return 8'h80;
            default: return 8'h20;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive, check qualifier, update model at the edge, check state.
    task automatic cyc(input bit p, input logic [12:0] a, input logic [7:0] d, input bit ps);
        bit mexp, mfirst, mbusy, wa;
        string tag;
        @(negedge clk);
        wr_pulse = p; wr_addr = a; wr_data = d; protect_set = ps;
        #1;
        mbusy  = (m_cnt != 0);
        mexp   = (a == cmd_addr(m_step)) && (d == cmd_data(m_step));
        mfirst = (a == 13'h1555) && (d == 8'hAA);
        wa = p && !m_prot && !mbusy && !(mexp || mfirst);
        if (m_prot) tag = "R7"; else if (mbusy) tag = "R6";
        else if (p && (mexp || mfirst)) tag = "R8"; else tag = "R10";
        check(write_allowed == wa, tag, write_allowed, wa);
        @(posedge clk);
        if (ps) m_prot = 1'b1;
        else if (m_cnt == 1) m_prot = 1'b0;
        if (m_cnt != 0) m_cnt--;
        if (p && !mbusy) begin
            if (mexp) begin
                if (m_step == 5) begin m_step = 0; m_cnt = TWC; end
                else m_step++;
            end else m_step = mfirst ? 1 : 0;
        end
        #1;
        check(busy == (m_cnt != 0), "R3", busy, int'(m_cnt != 0));
        check(prot_en == m_prot, "R4", prot_en, m_prot);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b0);
    endtask

    task automatic send_steps(input int first, input int last);
        for (int i = first; i <= last; i++) cyc(1'b1, cmd_addr(i), cmd_data(i), 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(prot_en == 1'b1, "R1", prot_en, 1);
        check(busy == 1'b0, "R1", busy, 0);
        @(negedge clk); rst_n = 1'b1;
        // R7: ordinary write while protected
        cyc(1'b1, 13'h0123, 8'h5A, 1'b0);
        // R2: full command with a gap, busy next cycle
        send_steps(0, 2); idle(2); send_steps(3, 5);
        check(busy == 1'b1, "R2", busy, 1);
        check(prot_en == 1'b1, "R4", prot_en, 1);
        // R6: complete command attempted while busy must not restart anything
        send_steps(0, 5);
        idle(TWC - 6 - 1);
        check(busy == 1'b1, "R3", busy, 1);
        idle(1);
        check(busy == 1'b0, "R3", busy, 0);
        check(prot_en == 1'b0, "R4", prot_en, 0);
        idle(3);
        check(busy == 1'b0, "R6", busy, 0);
        // R10 and R8: ordinary write passes, command writes do not
        cyc(1'b1, 13'h0042, 8'h11, 1'b0);
        cyc(1'b1, 13'h1555, 8'hAA, 1'b0);
        cyc(1'b1, 13'h0AAA, 8'h55, 1'b0);
        cyc(1'b1, 13'h0AAA, 8'h77, 1'b0);
        // R5: restart at step three by 0xAA@0x1555, then finish in five writes
        send_steps(0, 1);
        send_steps(0, 5 - 0 - 0 - 0 - 0 - 0 + 0 - 0);
        check(busy == 1'b1, "R5", busy, 1);
        idle(TWC - 1);
        // R9: protect_set in the last busy cycle wins over the clear
        cyc(1'b0, '0, '0, 1'b1);
        check(prot_en == 1'b1, "R9", prot_en, 1);
        check(busy == 1'b0, "R9", busy, 0);
        // R5: junk write breaks the command, later steps do not complete it
        send_steps(0, 2);
        cyc(1'b1, 13'h1555, 8'h21, 1'b0);
        send_steps(3, 5);
        check(busy == 1'b0, "R5", busy, 0);
        // Random traffic favouring the expected step and the restart pattern
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            bit ps = ($urandom_range(0, 199) == 0);
            if (r < 20) cyc(1'b0, '0, '0, ps);
            else if (r < 75) cyc(1'b1, cmd_addr(m_step), cmd_data(m_step), ps);
            else if (r < 85) cyc(1'b1, 13'h1555, 8'hAA, ps);
            else cyc(1'b1, 13'($urandom), 8'($urandom), ps);
        end
        // R1: reset in the middle of a busy window
        send_steps(0, 5);
        @(negedge clk); rst_n = 1'b0; wr_pulse = 1'b0; protect_set = 1'b0;
        @(posedge clk); #1;
        check(busy == 1'b0, "R1", busy, 0);
        check(prot_en == 1'b1, "R1", prot_en, 1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule